// File: doc/BRIEF.md
# Time-Slot Thread Issue Sequencer

This block chooses, on every clock, which of up to four hardware threads sharing one processor core may issue an instruction. It walks a programmable table of sixteen slots. Each slot holds a thread number, and the block uses one slot per clock in circular order. Threads are therefore interleaved clock by clock, and software sets each thread's share of the core by how many slots carry its number. Any split is allowed: one thread may own all sixteen slots, or one may take fifteen while another keeps one.

Software loads the whole table at once as a single wide word. The load also rewinds the scan to slot 0, so the grant phase for the next sixteen clocks is known exactly. A thread that appears in no slot gets no issue cycles, so its state goes quiet and can be read or replaced safely. The block raises a per-thread "starved" flag once a fixed pipeline-drain delay has passed since the load. A thread that gets slots back loses the flag at once and resumes where it stopped. Nothing that holds thread state belongs to this block.

Top module: `slot_sequencer`

## Requirements
- R1: After reset, all slots hold thread 0 and the scan is at slot 0. The outputs read `cur_task`=0, `issue_en`=4'b0001 and `task_starved`=4'b1110.
- R2: Slot k of the table is the 2-bit field at bits [2k+1:2k] of `map_wr_data`. Slot 0 is in bits [1:0].
- R3: When `map_wr_en` is sampled high at a clock edge, `cur_task` shows slot 0 of the written word during the following cycle.
- R4: Each later clock advances the scan by one slot, from slot 15 back to slot 0, with no write needed.
- R5: `issue_en` is always one-hot, and its set bit is bit `cur_task`.
- R6: Any distribution of the sixteen slots is honoured. With fifteen slots for one thread and one for another, a 16-cycle window grants them fifteen cycles and one cycle.
- R7: A thread whose flag in `task_starved` is set never has its `issue_en` bit set.
- R8: Suppose a write removes a thread that was not starved. Its starved flag stays low for the first DRAIN_DEPTH-1 cycles after the write edge and is high from the DRAIN_DEPTH-th edge after it.
- R9: A write that places a thread in at least one slot clears that thread's starved flag in the very next cycle.
- R10: A write during any scan position restarts the scan at slot 0 of the new table. With writes on consecutive clocks, the last one wins.
- R11: A starved thread that is absent from a newly written table keeps its flag high on every cycle through the drain period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| map_wr_en | input | 1 | Load strobe for the slot table |
| map_wr_data | input | 32 | New slot table, 2 bits per slot |
| cur_task | output | 2 | Thread granted in this cycle |
| issue_en | output | 4 | One-hot issue enable per thread |
| task_starved | output | 4 | Thread holds no slot and its pipeline has drained |

## Verification
Some rules are checked by assertions on every cycle. The issue enable must stay one-hot and match the current thread. It must never go to a starved thread. The first grant after a load must come from slot 0 of the loaded word. A starved flag must clear at once when a load gives its thread a slot, and otherwise hold steady. Other behaviour depends on the table contents over many cycles, and only the bench's scenarios can show it: the order in which slots are scanned, the exact edge at which a drain completes, the 15-to-1 split, and restart on a load in mid-scan or on back-to-back loads. The bench checks these against its own cycle-by-cycle expectation.

// File: rtl/slot_seq_pkg.sv
package slot_seq_pkg;
  localparam int DEF_TASKS = 4;
  localparam int DEF_SLOTS = 16;
  localparam int DEF_DRAIN = 6;

  function automatic int tid_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/slot_scanner.sv
module slot_scanner
  import slot_seq_pkg::*;
#(
  parameter int NUM_TASKS = DEF_TASKS,
  parameter int NUM_SLOTS = DEF_SLOTS,
  localparam int TID_W = tid_width(NUM_TASKS),
  localparam int IDX_W = $clog2(NUM_SLOTS),
  localparam int MAP_W = NUM_SLOTS * TID_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [MAP_W-1:0]     wr_map,
  output logic [MAP_W-1:0]     map_q,
  output logic [TID_W-1:0]     cur_task,
  output logic [NUM_TASKS-1:0] issue_en
);
  logic [IDX_W-1:0]     idx_q;
  logic [IDX_W-1:0]     idx_nxt;
  logic [TID_W-1:0]     entry [NUM_SLOTS];
  logic [TID_W-1:0]     task_nxt;
  logic [NUM_TASKS-1:0] issue_nxt;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_entry
    assign entry[s] = map_q[s*TID_W +: TID_W];
  end

  assign idx_nxt  = (idx_q == IDX_W'(NUM_SLOTS-1)) ? '0 : idx_q + 1'b1;
  assign task_nxt = wr_en ? wr_map[TID_W-1:0] : entry[idx_nxt];

  for (genvar t = 0; t < NUM_TASKS; t++) begin : g_issue
    assign issue_nxt[t] = (task_nxt == TID_W'(t));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      map_q    <= '0;
      idx_q    <= '0;
      cur_task <= '0;
      issue_en <= NUM_TASKS'(1);
    end else begin
      if (wr_en) begin
        map_q <= wr_map;
        idx_q <= '0;
      end else begin
        idx_q <= idx_nxt;
      end
      cur_task <= task_nxt;
      issue_en <= issue_nxt;
    end
  end
endmodule

// File: rtl/starve_tracker.sv
module starve_tracker
  import slot_seq_pkg::*;
#(
  parameter int NUM_TASKS   = DEF_TASKS,
  parameter int NUM_SLOTS   = DEF_SLOTS,
  parameter int DRAIN_DEPTH = DEF_DRAIN,
  localparam int TID_W = tid_width(NUM_TASKS),
  localparam int MAP_W = NUM_SLOTS * TID_W,
  localparam int CNT_W = $clog2(DRAIN_DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [MAP_W-1:0]     wr_map,
  input  logic [MAP_W-1:0]     map_q,
  output logic [NUM_TASKS-1:0] starved
);
  logic [NUM_TASKS-1:0] new_holds;
  logic [NUM_TASKS-1:0] cur_holds;
  logic [CNT_W-1:0]     drain_cnt;

  for (genvar t = 0; t < NUM_TASKS; t++) begin : g_holds
    always_comb begin
      new_holds[t] = 1'b0;
      cur_holds[t] = 1'b0;
      for (int s = 0; s < NUM_SLOTS; s++) begin
        if (wr_map[s*TID_W +: TID_W] == TID_W'(t)) new_holds[t] = 1'b1;
        if (map_q[s*TID_W +: TID_W]  == TID_W'(t)) cur_holds[t] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      drain_cnt <= CNT_W'(DRAIN_DEPTH);
      starved   <= ~NUM_TASKS'(1);
    end else if (wr_en) begin
      drain_cnt <= '0;
      starved   <= starved & ~new_holds;
    end else if (drain_cnt != CNT_W'(DRAIN_DEPTH)) begin
      drain_cnt <= drain_cnt + 1'b1;
      if (drain_cnt == CNT_W'(DRAIN_DEPTH-1)) starved <= ~cur_holds;
    end
  end
endmodule

// File: rtl/slot_sequencer.sv
module slot_sequencer
  import slot_seq_pkg::*;
#(
  parameter int NUM_TASKS   = DEF_TASKS,
  parameter int NUM_SLOTS   = DEF_SLOTS,
  parameter int DRAIN_DEPTH = DEF_DRAIN,
  localparam int TID_W = tid_width(NUM_TASKS),
  localparam int MAP_W = NUM_SLOTS * TID_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 map_wr_en,
  input  logic [MAP_W-1:0]     map_wr_data,
  output logic [TID_W-1:0]     cur_task,
  output logic [NUM_TASKS-1:0] issue_en,
  output logic [NUM_TASKS-1:0] task_starved
);
  logic [MAP_W-1:0] map_q;

  slot_scanner #(.NUM_TASKS(NUM_TASKS), .NUM_SLOTS(NUM_SLOTS)) u_scan (
    .clk(clk), .rst(rst), .wr_en(map_wr_en), .wr_map(map_wr_data),
    .map_q(map_q), .cur_task(cur_task), .issue_en(issue_en)
  );

  starve_tracker #(.NUM_TASKS(NUM_TASKS), .NUM_SLOTS(NUM_SLOTS),
                   .DRAIN_DEPTH(DRAIN_DEPTH)) u_starve (
    .clk(clk), .rst(rst), .wr_en(map_wr_en), .wr_map(map_wr_data),
    .map_q(map_q), .starved(task_starved)
  );
endmodule

// File: rtl/slot_seq_checker.sv
module slot_seq_checker
  import slot_seq_pkg::*;
#(
  parameter int NUM_TASKS = DEF_TASKS,
  parameter int NUM_SLOTS = DEF_SLOTS,
  localparam int TID_W = tid_width(NUM_TASKS),
  localparam int MAP_W = NUM_SLOTS * TID_W
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 map_wr_en,
  input logic [MAP_W-1:0]     map_wr_data,
  input logic [TID_W-1:0]     cur_task,
  input logic [NUM_TASKS-1:0] issue_en,
  input logic [NUM_TASKS-1:0] task_starved
);
  logic [NUM_TASKS-1:0] wr_has;

  always_comb begin
    wr_has = '0;
    for (int t = 0; t < NUM_TASKS; t++)
      for (int s = 0; s < NUM_SLOTS; s++)
        if (map_wr_data[s*TID_W +: TID_W] == TID_W'(t)) wr_has[t] = 1'b1;
  end

  assert_issue_onehot_R5: assert property (@(posedge clk) disable iff (rst)
    ($countones(issue_en) == 1) && issue_en[cur_task]);

  assert_starved_no_issue_R7: assert property (@(posedge clk) disable iff (rst)
    (task_starved & issue_en) == '0);

  assert_write_slot0_R3: assert property (@(posedge clk) disable iff (rst)
    map_wr_en |=> (cur_task == $past(map_wr_data[TID_W-1:0])));

  for (genvar t = 0; t < NUM_TASKS; t++) begin : g_task
    assert_regain_clears_R9: assert property (@(posedge clk) disable iff (rst)
      (map_wr_en && wr_has[t]) |=> !task_starved[t]);

    assert_starved_holds_R11: assert property (@(posedge clk) disable iff (rst)
      (task_starved[t] && !(map_wr_en && wr_has[t])) |=> task_starved[t]);
  end
endmodule

bind slot_sequencer slot_seq_checker #(.NUM_TASKS(NUM_TASKS), .NUM_SLOTS(NUM_SLOTS)) u_chk (
  .clk(clk), .rst(rst), .map_wr_en(map_wr_en), .map_wr_data(map_wr_data),
  .cur_task(cur_task), .issue_en(issue_en), .task_starved(task_starved)
);

// File: tb/slot_sequencer_test.sv
module slot_sequencer_test;
  localparam int D = 6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        map_wr_en = 1'b0;
  logic [31:0] map_wr_data = '0;
  logic [1:0]  cur_task;
  logic [3:0]  issue_en;
  logic [3:0]  task_starved;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [31:0] m_map;
  int          m_idx;
  logic [3:0]  m_st;
  int          m_cnt;
  bit          m_wrote;

  always #5 clk = ~clk;

  slot_sequencer #(.NUM_TASKS(4), .NUM_SLOTS(16), .DRAIN_DEPTH(D)) uut (
    .clk(clk), .rst(rst), .map_wr_en(map_wr_en), .map_wr_data(map_wr_data),
    .cur_task(cur_task), .issue_en(issue_en), .task_starved(task_starved)
  );

  function automatic logic [1:0] fld(input logic [31:0] m, input int k);
    return m[2*k +: 2];
  endfunction

  function automatic logic [3:0] holds(input logic [31:0] m);
    logic [3:0] h = '0;
    for (int k = 0; k < 16; k++) h[fld(m, k)] = 1'b1;
    return h;
  endfunction

  function automatic logic [31:0] fill(input logic [1:0] t);
    logic [31:0] m;
    for (int k = 0; k < 16; k++) m[2*k +: 2] = t;
    return m;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one clock: drive at negedge, update expectation at posedge, compare at next negedge
  task automatic step(input bit wr, input logic [31:0] data);
    map_wr_en   = wr;
    map_wr_data = data;
    @(posedge clk);
    m_wrote = wr;
    if (wr) begin
      m_st  = m_st & ~holds(data);
      m_cnt = 0;
      m_map = data;
      m_idx = 0;
    end else begin
      m_idx = (m_idx + 1) % 16;
      if (m_cnt < D) begin
        m_cnt++;
        if (m_cnt == D) m_st = ~holds(m_map);
      end
    end
    @(negedge clk);
    map_wr_en = 1'b0;
    chk(cur_task == fld(m_map, m_idx), m_wrote ? "R3 slot0 after write" : "R4 scan order",
        cur_task, fld(m_map, m_idx));
    chk(issue_en == (4'b1 << fld(m_map, m_idx)), "R5 issue onehot",
        issue_en, 4'b1 << fld(m_map, m_idx));
    chk(task_starved == m_st, "R8 starved timing", task_starved, m_st);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] m;
    int c1, c2;
    void'($urandom(32'd20240611));
    m_map = '0; m_idx = 0; m_st = 4'b1110; m_cnt = D; m_wrote = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    @(negedge clk);
    // R1 reset state (one edge after reset release: scan moved to slot 1, still thread 0)
    m_idx = 1;
    chk(cur_task == 2'd0, "R1 reset cur_task", cur_task, 0);
    chk(issue_en == 4'b0001, "R1 reset issue_en", issue_en, 1);
    chk(task_starved == 4'b1110, "R1 reset starved", task_starved, 4'he);

    // R2 field layout: slot 5 alone holds thread 3
    m = fill(2'd1);
    m[11:10] = 2'd3;
    step(1'b1, m);
    for (int k = 1; k < 16; k++) begin
      step(1'b0, '0);
      if (k == 5) chk(cur_task == 2'd3, "R2 slot5 field", cur_task, 3);
      else        chk(cur_task == 2'd1, "R2 other field", cur_task, 1);
    end

    // R6 15/1 split, thread 2 gets slot 9
    m = fill(2'd0);
    m[19:18] = 2'd2;
    step(1'b1, m);
    c1 = 0; c2 = 0;
    for (int k = 0; k < 16; k++) begin
      if (k > 0) step(1'b0, '0);
      if (issue_en[0]) c1++;
      if (issue_en[2]) c2++;
    end
    chk(c1 == 15, "R6 share of thread0", c1, 15);
    chk(c2 == 1, "R6 share of thread2", c2, 1);

    // R8 drain: remove thread 0 (not starved), give all to thread 1
    step(1'b1, fill(2'd1));
    chk(task_starved[1] == 1'b0, "R9 regained thread1", task_starved[1], 0);
    for (int k = 1; k < D; k++) begin
      step(1'b0, '0);
      chk(task_starved[0] == 1'b0, "R8 before drain", task_starved[0], 0);
    end
    step(1'b0, '0);
    chk(task_starved[0] == 1'b1, "R8 after drain", task_starved[0], 1);
    chk(issue_en[0] == 1'b0, "R7 starved no issue", issue_en[0], 0);

    // R11 / R9: thread 0 stays starved, thread 2 regains slots at once
    step(1'b1, fill(2'd2));
    chk(task_starved[2] == 1'b0, "R9 regained thread2", task_starved[2], 0);
    for (int k = 0; k < D + 2; k++) begin
      chk(task_starved[0] == 1'b1, "R11 stays starved", task_starved[0], 1);
      step(1'b0, '0);
    end

    // R10 mid-scan write, then back-to-back writes
    step(1'b1, 32'h1B1B_1B1B);
    repeat (7) step(1'b0, '0);
    step(1'b1, 32'hE4E4_E4E6);
    chk(cur_task == 2'd2, "R10 mid-scan restart", cur_task, 2);
    step(1'b1, 32'h5555_5557);
    chk(cur_task == 2'd3, "R10 back-to-back last wins", cur_task, 3);
    step(1'b0, '0);
    chk(cur_task == 2'd1, "R10 then slot1", cur_task, 1);

    // constrained random: random allowed-thread sets, random write spacing
    for (int n = 0; n < 1500; n++) begin
      if ($urandom_range(0, 11) == 0) begin
        logic [3:0] allow;
        allow = 4'($urandom_range(1, 15));
        for (int k = 0; k < 16; k++) begin
          logic [1:0] t;
          t = 2'($urandom_range(0, 3));
          while (!allow[t]) t = t + 2'd1;
          m[2*k +: 2] = t;
        end
        step(1'b1, m);
      end else begin
        step(1'b0, '0);
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule